// File: doc/BRIEF.md
# Branch Prediction Control Unit

This block sits in the fetch stage of a pipelined core. For each control-transfer instruction it receives a class (unconditional, call, return, direct) and a direction guess, and it produces a registered next-PC prediction one cycle later. The target comes from one of three places. A 16-entry return stack supplies return targets. An external target buffer supplies direct targets. An external indirect target table supplies indirect targets. When no target is found, the block falls back to the sequential PC. The direction predictor, the target buffer and the indirect table are outside the block. They answer combinationally through hit/target ports, and they receive training and updates through registered output ports.

Every accepted prediction is logged, with its sequence number, in a 16-entry history queue. Later the pipeline can commit old predictions, which retires them oldest-first and sends each final direction out for training. It can squash young predictions, which removes them youngest-first and undoes their effect on the return stack. A mispredict report overwrites the stored direction of the named entry. When the actual outcome was taken, it also sends the corrected target to the target buffer or to the indirect table. Commit and squash drain one queue entry per clock cycle.

Top module: `brpred_ctrl`

## Requirements
- R1: An accepted prediction with br_uncond=1 is guessed taken whatever dir_guess is; with br_uncond=0 the guess equals dir_guess.
- R2: A guessed-taken return (br_ret=1) predicts taken with the top of the return stack as target, then pops the stack; the target buffer and the indirect table are not consulted.
- R3: A guessed-taken call (br_call=1) that is kept on the stack pushes its PC plus INST_BYTES onto the return stack.
- R4: A guessed-taken non-return with br_direct=1 (or USE_IND=0) uses the target buffer: on btb_hit=1 the prediction is taken with btb_tgt, on a miss it is not taken with npc equal to PC plus INST_BYTES.
- R5: A guessed-taken non-return with br_direct=0 (USE_IND=1) uses the indirect table and ignores btb_hit/btb_tgt: on ind_hit=1 it is taken with ind_tgt, on a miss not taken with npc equal to PC plus INST_BYTES, and the entry is marked indirect.
- R6: A conditional call whose target lookup misses leaves the return stack unchanged, while an unconditional call that misses still keeps its push.
- R7: A commit request with sequence N retires, one per cycle and oldest first, every queue entry whose sequence is at most N, each retirement raising trn_vld with the entry's PC and final direction.
- R8: A squash request with sequence N removes, one per cycle and youngest first, every entry whose sequence is greater than N; a removed entry that used the stack restores the saved top index and value, and one that pushed pops the stack.
- R9: A mispredict report that matches a queued entry overwrites its direction with misp_tkn; when misp_tkn=1, the next cycle raises btb_upd_vld (entry not indirect) or ind_upd_vld (entry indirect), never both, carrying misp_tgt.
- R10: The queue holds HQ_DEPTH=16 entries; when it is full, hq_full=1 and pred_rdy=0, and no prediction is accepted. The return stack holds 16 entries, and its top pointer wraps, so the 17th push overwrites the slot of the 1st.
- R11: Same-cycle requests are serviced squash first, then commit, then predict: a squash request or a pending squash drops pred_rdy, and commit retirements start only after the squash has drained.
- R12: npc_vld, npc_tkn and npc update one cycle after an accepted prediction, and npc_vld is low in every other cycle. After reset, no output valid is high, pred_rdy=1 and hq_full=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction request |
| pred_seq | input | SEQ_W | Sequence number of the request |
| pred_pc | input | PC_W | PC of the control-transfer instruction |
| br_uncond | input | 1 | 1 = unconditional transfer |
| br_call | input | 1 | 1 = call |
| br_ret | input | 1 | 1 = return |
| br_direct | input | 1 | 1 = direct target, 0 = indirect |
| dir_guess | input | 1 | Direction predictor answer (1 = taken) |
| btb_hit | input | 1 | Target buffer hit for pred_pc |
| btb_tgt | input | PC_W | Target buffer target |
| ind_hit | input | 1 | Indirect table hit |
| ind_tgt | input | PC_W | Indirect table target |
| pred_rdy | output | 1 | Prediction request can be accepted this cycle |
| hq_full | output | 1 | History queue holds HQ_DEPTH entries |
| npc_vld | output | 1 | Registered prediction valid |
| npc_tkn | output | 1 | Prediction is taken |
| npc | output | PC_W | Predicted next PC |
| cmt_req | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Commit up to and including this sequence |
| sq_req | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash everything younger than this sequence |
| misp_vld | input | 1 | Mispredict report |
| misp_seq | input | SEQ_W | Sequence of the mispredicted entry |
| misp_tkn | input | 1 | Actual direction |
| misp_tgt | input | PC_W | Actual target |
| trn_vld | output | 1 | Direction training for a retired entry |
| trn_pc | output | PC_W | PC of the retired entry |
| trn_tkn | output | 1 | Final direction of the retired entry |
| btb_upd_vld | output | 1 | Target buffer update |
| btb_upd_pc | output | PC_W | PC to update in the target buffer |
| btb_upd_tgt | output | PC_W | Corrected target for the target buffer |
| ind_upd_vld | output | 1 | Indirect table update |
| ind_upd_seq | output | SEQ_W | Sequence of the indirect entry |
| ind_upd_tgt | output | PC_W | Corrected indirect target |

## Verification
A squash and a commit can be requested in the same cycle as a new prediction, and they act on opposite ends of the same queue. The bench raises squash, commit and predict on one clock edge, with a commit bound that covers entries the squash also removes. It expects the prediction to be refused (pred_rdy low, no npc_vld), and it expects only the entries older than the squash bound to appear on the training port. A fourth check follows a squash of a call and a return: the next return must predict the older call's return address, which shows that the stack was repaired before the queue accepted new work.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  // Which source drives the predicted next PC
  typedef enum logic [1:0] {
    TSRC_SEQ = 2'd0,
    TSRC_RAS = 2'd1,
    TSRC_BTB = 2'd2,
    TSRC_IND = 2'd3
  } tsrc_e;
endpackage

// File: rtl/bpc_ret_stack.sv
// Circular return-address stack; top pointer wraps on overflow/underflow.
module bpc_ret_stack #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [PC_W-1:0]            push_val,
  input  logic                       pop,
  input  logic                       restore,
  input  logic [$clog2(DEPTH)-1:0]   rs_idx,
  input  logic [PC_W-1:0]            rs_val,
  output logic [$clog2(DEPTH)-1:0]   top_idx,
  output logic [PC_W-1:0]            top_val
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [IDX_W-1:0] tp;
  logic [IDX_W-1:0] tp_up;

  assign tp_up = tp + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          tp <= '0;
    else if (restore) tp <= rs_idx;
    else if (push)    tp <= tp_up;
    else if (pop)     tp <= tp - 1'b1;
  end

  // single write port, no reset: maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (restore)   mem[rs_idx] <= rs_val;
    else if (push) mem[tp_up]  <= push_val;
  end

  assign top_idx = tp;
  assign top_val = mem[tp];
endmodule

// File: rtl/bpc_hist_q.sv
// Sequence-tagged prediction history: push at the young end, pop at either end,
// associative direction fix by sequence number.
module bpc_hist_q #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [PC_W-1:0]   push_pc,
  input  logic              push_tkn,
  input  logic              push_used,
  input  logic [RIDX_W-1:0] push_ridx,
  input  logic [PC_W-1:0]   push_rval,
  input  logic              push_pushed,
  input  logic              push_ind,
  input  logic              pop_head,
  input  logic              pop_tail,
  input  logic              fix_vld,
  input  logic [SEQ_W-1:0]  fix_seq,
  input  logic              fix_tkn,
  output logic              fix_hit,
  output logic [PC_W-1:0]   fix_pc,
  output logic              fix_ind,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [PC_W-1:0]   head_pc,
  output logic              head_tkn,
  output logic [SEQ_W-1:0]  tail_seq,
  output logic              tail_used,
  output logic [RIDX_W-1:0] tail_ridx,
  output logic [PC_W-1:0]   tail_rval,
  output logic              tail_pushed,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]  hd, tl, tl_m1;
  logic [CNT_W-1:0]  cnt;
  logic              e_vld    [DEPTH];
  logic [SEQ_W-1:0]  e_seq    [DEPTH];
  logic [PC_W-1:0]   e_pc     [DEPTH];
  logic              e_tkn    [DEPTH];
  logic              e_used   [DEPTH];
  logic [RIDX_W-1:0] e_ridx   [DEPTH];
  logic [PC_W-1:0]   e_rval   [DEPTH];
  logic              e_pushed [DEPTH];
  logic              e_ind    [DEPTH];
  logic [DEPTH-1:0]  match;

  assign tl_m1 = tl - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) e_vld[i] <= 1'b0;
    end else begin
      if (push)          tl <= tl + 1'b1;
      else if (pop_tail) tl <= tl_m1;
      if (pop_head)      hd <= hd + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop_head | pop_tail);
      for (int i = 0; i < DEPTH; i++) begin
        if (push && PTR_W'(i) == tl)
          e_vld[i] <= 1'b1;
        else if ((pop_head && PTR_W'(i) == hd) || (pop_tail && PTR_W'(i) == tl_m1))
          e_vld[i] <= 1'b0;
      end
    end
  end

  // payload: no reset, guarded by e_vld
  always_ff @(posedge clk) begin
    if (push) begin
      e_seq[tl]    <= push_seq;
      e_pc[tl]     <= push_pc;
      e_used[tl]   <= push_used;
      e_ridx[tl]   <= push_ridx;
      e_rval[tl]   <= push_rval;
      e_pushed[tl] <= push_pushed;
      e_ind[tl]    <= push_ind;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push && PTR_W'(i) == tl)     e_tkn[i] <= push_tkn;
      else if (fix_vld && match[i])    e_tkn[i] <= fix_tkn;
    end
  end

  always_comb begin
    fix_hit = 1'b0;
    fix_pc  = '0;
    fix_ind = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = e_vld[i] && (e_seq[i] == fix_seq);
      if (match[i]) begin
        fix_hit = 1'b1;
        fix_pc  = e_pc[i];
        fix_ind = e_ind[i];
      end
    end
  end

  assign head_seq    = e_seq[hd];
  assign head_pc     = e_pc[hd];
  assign head_tkn    = e_tkn[hd];
  assign tail_seq    = e_seq[tl_m1];
  assign tail_used   = e_used[tl_m1];
  assign tail_ridx   = e_ridx[tl_m1];
  assign tail_rval   = e_rval[tl_m1];
  assign tail_pushed = e_pushed[tl_m1];
  assign full        = (cnt == CNT_W'(DEPTH));
  assign empty       = (cnt == '0);
endmodule

// File: rtl/brpred_ctrl.sv
module brpred_ctrl
  import bpc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int HQ_DEPTH   = 16,
  parameter int RAS_DEPTH  = 16,
  parameter int INST_BYTES = 4,
  parameter bit USE_IND    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_valid,
  input  logic [SEQ_W-1:0] pred_seq,
  input  logic [PC_W-1:0]  pred_pc,
  input  logic             br_uncond,
  input  logic             br_call,
  input  logic             br_ret,
  input  logic             br_direct,
  input  logic             dir_guess,
  input  logic             btb_hit,
  input  logic [PC_W-1:0]  btb_tgt,
  input  logic             ind_hit,
  input  logic [PC_W-1:0]  ind_tgt,
  output logic             pred_rdy,
  output logic             hq_full,
  output logic             npc_vld,
  output logic             npc_tkn,
  output logic [PC_W-1:0]  npc,
  input  logic             cmt_req,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             sq_req,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             misp_vld,
  input  logic [SEQ_W-1:0] misp_seq,
  input  logic             misp_tkn,
  input  logic [PC_W-1:0]  misp_tgt,
  output logic             trn_vld,
  output logic [PC_W-1:0]  trn_pc,
  output logic             trn_tkn,
  output logic             btb_upd_vld,
  output logic [PC_W-1:0]  btb_upd_pc,
  output logic [PC_W-1:0]  btb_upd_tgt,
  output logic             ind_upd_vld,
  output logic [SEQ_W-1:0] ind_upd_seq,
  output logic [PC_W-1:0]  ind_upd_tgt
);
  localparam int RIDX_W = $clog2(RAS_DEPTH);

  // ---------------- prediction decode ----------------
  logic            guess, use_btb, lk_hit, ret_tk, ind_look, final_tk, call_push;
  logic [PC_W-1:0] seq_pc, tgt;
  tsrc_e           tsrc;

  assign seq_pc    = pred_pc + PC_W'(INST_BYTES);
  assign guess     = br_uncond | dir_guess;
  assign use_btb   = br_direct | !USE_IND;
  assign lk_hit    = use_btb ? btb_hit : ind_hit;
  assign ret_tk    = guess & br_ret;
  assign ind_look  = guess & !br_ret & !use_btb;
  assign final_tk  = guess & (br_ret | lk_hit);
  // conditional call that misses: push cancelled (net of push-then-pop)
  assign call_push = guess & br_call & !br_ret & (lk_hit | br_uncond);

  logic [RIDX_W-1:0] ras_idx;
  logic [PC_W-1:0]   ras_top;

  always_comb begin
    if (!final_tk)     tsrc = TSRC_SEQ;
    else if (br_ret)   tsrc = TSRC_RAS;
    else if (use_btb)  tsrc = TSRC_BTB;
    else               tsrc = TSRC_IND;
    case (tsrc)
      TSRC_RAS: tgt = ras_top;
      TSRC_BTB: tgt = btb_tgt;
      TSRC_IND: tgt = ind_tgt;
      default:  tgt = seq_pc;
    endcase
  end

  // ---------------- queue sequencing ----------------
  logic             sq_pend, cm_pend;
  logic [SEQ_W-1:0] sq_lim, cm_lim;
  logic             q_empty, sq_pop, cm_pop, fire;
  logic [SEQ_W-1:0] head_seq, tail_seq;
  logic [PC_W-1:0]  head_pc;
  logic             head_tkn, tail_used, tail_pushed;
  logic [RIDX_W-1:0] tail_ridx;
  logic [PC_W-1:0]  tail_rval;
  logic             fix_hit, fix_ind;
  logic [PC_W-1:0]  fix_pc;

  assign sq_pop   = sq_pend && !q_empty && (tail_seq > sq_lim);
  assign cm_pop   = cm_pend && !sq_pend && !q_empty && (head_seq <= cm_lim);
  assign pred_rdy = !hq_full && !sq_pend && !sq_req;
  assign fire     = pred_valid && pred_rdy;

  bpc_ret_stack #(.DEPTH(RAS_DEPTH), .PC_W(PC_W)) u_ras (
    .clk      (clk),
    .rst      (rst),
    .push     (fire & call_push),
    .push_val (seq_pc),
    .pop      ((fire & ret_tk) | (sq_pop & tail_pushed)),
    .restore  (sq_pop & tail_used),
    .rs_idx   (tail_ridx),
    .rs_val   (tail_rval),
    .top_idx  (ras_idx),
    .top_val  (ras_top)
  );

  bpc_hist_q #(.DEPTH(HQ_DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .RIDX_W(RIDX_W)) u_hq (
    .clk         (clk),
    .rst         (rst),
    .push        (fire),
    .push_seq    (pred_seq),
    .push_pc     (pred_pc),
    .push_tkn    (final_tk),
    .push_used   (ret_tk),
    .push_ridx   (ras_idx),
    .push_rval   (ras_top),
    .push_pushed (call_push),
    .push_ind    (ind_look),
    .pop_head    (cm_pop),
    .pop_tail    (sq_pop),
    .fix_vld     (misp_vld),
    .fix_seq     (misp_seq),
    .fix_tkn     (misp_tkn),
    .fix_hit     (fix_hit),
    .fix_pc      (fix_pc),
    .fix_ind     (fix_ind),
    .head_seq    (head_seq),
    .head_pc     (head_pc),
    .head_tkn    (head_tkn),
    .tail_seq    (tail_seq),
    .tail_used   (tail_used),
    .tail_ridx   (tail_ridx),
    .tail_rval   (tail_rval),
    .tail_pushed (tail_pushed),
    .full        (hq_full),
    .empty       (q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_pend     <= 1'b0;
      sq_lim      <= '0;
      cm_pend     <= 1'b0;
      cm_lim      <= '0;
      npc_vld     <= 1'b0;
      npc_tkn     <= 1'b0;
      npc         <= '0;
      trn_vld     <= 1'b0;
      trn_pc      <= '0;
      trn_tkn     <= 1'b0;
      btb_upd_vld <= 1'b0;
      btb_upd_pc  <= '0;
      btb_upd_tgt <= '0;
      ind_upd_vld <= 1'b0;
      ind_upd_seq <= '0;
      ind_upd_tgt <= '0;
    end else begin
      if (sq_req) begin
        sq_pend <= 1'b1;
        sq_lim  <= sq_seq;
      end else if (sq_pend && !sq_pop) begin
        sq_pend <= 1'b0;
      end
      if (cmt_req) begin
        cm_pend <= 1'b1;
        cm_lim  <= cmt_seq;
      end else if (cm_pend && !sq_pend && !cm_pop) begin
        cm_pend <= 1'b0;
      end
      npc_vld <= fire;
      npc_tkn <= fire & final_tk;
      if (fire) npc <= tgt;
      trn_vld <= cm_pop;
      if (cm_pop) begin
        trn_pc  <= head_pc;
        trn_tkn <= head_tkn;
      end
      btb_upd_vld <= misp_vld & fix_hit & misp_tkn & !fix_ind;
      ind_upd_vld <= misp_vld & fix_hit & misp_tkn & fix_ind;
      if (misp_vld) begin
        btb_upd_pc  <= fix_pc;
        btb_upd_tgt <= misp_tgt;
        ind_upd_seq <= misp_seq;
        ind_upd_tgt <= misp_tgt;
      end
    end
  end
endmodule

// File: rtl/brpred_ctrl_chk.sv
module brpred_ctrl_chk #(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            pred_valid,
  input logic            pred_rdy,
  input logic            hq_full,
  input logic [PC_W-1:0] pred_pc,
  input logic            br_uncond,
  input logic            br_ret,
  input logic            br_direct,
  input logic            btb_hit,
  input logic            npc_vld,
  input logic            npc_tkn,
  input logic [PC_W-1:0] npc,
  input logic            sq_req,
  input logic            trn_vld,
  input logic            btb_upd_vld,
  input logic            ind_upd_vld
);
  logic acc;
  assign acc = pred_valid && pred_rdy;

  AST_UNCOND_HIT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    acc && br_uncond && !br_ret && br_direct && btb_hit |=> npc_vld && npc_tkn); // R1

  AST_DIRECT_MISS_SEQ: assert property (@(posedge clk) disable iff (rst)
    acc && !br_ret && br_direct && !btb_hit |=> !npc_tkn && (npc == $past(pred_pc) + PC_W'(INST_BYTES))); // R4

  AST_UPD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({btb_upd_vld, ind_upd_vld})); // R9

  AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    hq_full && pred_valid |=> !npc_vld); // R10

  AST_SQUASH_FIRST: assert property (@(posedge clk) disable iff (rst)
    sq_req |=> !npc_vld && !trn_vld); // R11

  AST_NPC_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !npc_vld); // R12
endmodule

bind brpred_ctrl brpred_ctrl_chk #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pred_valid  (pred_valid),
  .pred_rdy    (pred_rdy),
  .hq_full     (hq_full),
  .pred_pc     (pred_pc),
  .br_uncond   (br_uncond),
  .br_ret      (br_ret),
  .br_direct   (br_direct),
  .btb_hit     (btb_hit),
  .npc_vld     (npc_vld),
  .npc_tkn     (npc_tkn),
  .npc         (npc),
  .sq_req      (sq_req),
  .trn_vld     (trn_vld),
  .btb_upd_vld (btb_upd_vld),
  .ind_upd_vld (ind_upd_vld)
);

// File: tb/test_brpred_ctrl.sv
`timescale 1ns/100ps
module test_brpred_ctrl;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             pred_valid = 0, br_uncond = 0, br_call = 0, br_ret = 0, br_direct = 0, dir_guess = 0;
  logic [SEQ_W-1:0] pred_seq = '0;
  logic [PC_W-1:0]  pred_pc = '0, btb_tgt = '0, ind_tgt = '0, misp_tgt = '0;
  logic             btb_hit = 0, ind_hit = 0, cmt_req = 0, sq_req = 0, misp_vld = 0, misp_tkn = 0;
  logic [SEQ_W-1:0] cmt_seq = '0, sq_seq = '0, misp_seq = '0;
  logic             pred_rdy, hq_full, npc_vld, npc_tkn, trn_vld, trn_tkn;
  logic             btb_upd_vld, ind_upd_vld;
  logic [PC_W-1:0]  npc, trn_pc, btb_upd_pc, btb_upd_tgt, ind_upd_tgt;
  logic [SEQ_W-1:0] ind_upd_seq;

  brpred_ctrl i_brpred_ctrl (
    .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_seq(pred_seq), .pred_pc(pred_pc),
    .br_uncond(br_uncond), .br_call(br_call), .br_ret(br_ret), .br_direct(br_direct),
    .dir_guess(dir_guess), .btb_hit(btb_hit), .btb_tgt(btb_tgt), .ind_hit(ind_hit),
    .ind_tgt(ind_tgt), .pred_rdy(pred_rdy), .hq_full(hq_full), .npc_vld(npc_vld),
    .npc_tkn(npc_tkn), .npc(npc), .cmt_req(cmt_req), .cmt_seq(cmt_seq), .sq_req(sq_req),
    .sq_seq(sq_seq), .misp_vld(misp_vld), .misp_seq(misp_seq), .misp_tkn(misp_tkn),
    .misp_tgt(misp_tgt), .trn_vld(trn_vld), .trn_pc(trn_pc), .trn_tkn(trn_tkn),
    .btb_upd_vld(btb_upd_vld), .btb_upd_pc(btb_upd_pc), .btb_upd_tgt(btb_upd_tgt),
    .ind_upd_vld(ind_upd_vld), .ind_upd_seq(ind_upd_seq), .ind_upd_tgt(ind_upd_tgt)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [SEQ_W-1:0] seq_n = 16'd1;
  logic [PC_W-1:0]  got_pc [64];
  logic             got_tk [64];
  int               got_n;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one prediction; outputs checked by caller right after return
  task automatic do_pred(input logic [PC_W-1:0] pc, input logic unc, input logic call,
                         input logic ret, input logic dir, input logic g,
                         input logic bh, input logic [PC_W-1:0] bt,
                         input logic ih, input logic [PC_W-1:0] it, output logic acc);
    @(negedge clk);
    pred_pc = pc; br_uncond = unc; br_call = call; br_ret = ret; br_direct = dir;
    dir_guess = g; btb_hit = bh; btb_tgt = bt; ind_hit = ih; ind_tgt = it;
    pred_seq = seq_n; pred_valid = 1'b1;
    #1 acc = pred_rdy;
    @(negedge clk);
    pred_valid = 1'b0;
    if (acc) seq_n++;
  endtask

  task automatic collect();
    got_n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (trn_vld) begin
        got_pc[got_n] = trn_pc;
        got_tk[got_n] = trn_tkn;
        got_n++;
      end
    end
  endtask

  task automatic do_commit(input logic [SEQ_W-1:0] s);
    @(negedge clk);
    cmt_req = 1'b1; cmt_seq = s;
    @(negedge clk);
    cmt_req = 1'b0;
    collect();
  endtask

  task automatic flush();
    do_commit(seq_n - 1'b1);
  endtask

  task automatic do_squash(input logic [SEQ_W-1:0] s);
    @(negedge clk);
    sq_req = 1'b1; sq_seq = s;
    #1 chk("R11 pred_rdy low with squash request", pred_rdy, 0);
    @(negedge clk);
    sq_req = 1'b0;
    for (int k = 0; k < 40 && !pred_rdy; k++) @(negedge clk);
  endtask

  task automatic do_misp(input logic [SEQ_W-1:0] s, input logic tk, input logic [PC_W-1:0] t);
    @(negedge clk);
    misp_vld = 1'b1; misp_seq = s; misp_tkn = tk; misp_tgt = t;
    @(negedge clk);
    misp_vld = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R12 reset npc_vld", npc_vld, 0);
    chk("R12 reset trn_vld", trn_vld, 0);
    chk("R12 reset upd valids", {btb_upd_vld, ind_upd_vld}, 0);
    chk("R12 reset pred_rdy", pred_rdy, 1);
    chk("R12 reset hq_full", hq_full, 0);
  endtask

  task automatic t_direct();
    logic a;
    do_pred(32'h100, 1, 0, 0, 1, 0, 1, 32'h800, 0, 0, a);
    chk("R1 uncond taken despite guess 0", {npc_vld, npc_tkn}, 2'b11);
    chk("R4 btb target", npc, 32'h800);
    do_pred(32'h100, 0, 0, 0, 1, 0, 1, 32'h800, 0, 0, a);
    chk("R1 cond guess 0 not taken", {npc_vld, npc_tkn}, 2'b10);
    chk("R1 cond guess 0 seq pc", npc, 32'h104);
    do_pred(32'h140, 0, 0, 0, 1, 1, 1, 32'h880, 0, 0, a);
    chk("R1 cond guess 1 taken", npc_tkn, 1);
    chk("R4 cond hit target", npc, 32'h880);
    do_pred(32'h180, 0, 0, 0, 1, 1, 0, 32'h999, 0, 0, a);
    chk("R4 btb miss not taken", npc_tkn, 0);
    chk("R4 btb miss seq pc", npc, 32'h184);
    do_pred(32'h1C0, 1, 0, 0, 1, 0, 0, 32'h999, 0, 0, a);
    chk("R4 uncond miss seq pc", {npc_tkn, npc}, {1'b0, 32'h1C4});
    @(negedge clk);
    chk("R12 npc_vld drops without request", npc_vld, 0);
    flush();
  endtask

  task automatic t_call_ret();
    logic a;
    do_pred(32'h200, 1, 1, 0, 1, 0, 1, 32'h900, 0, 0, a);
    chk("R3 call taken to btb target", npc, 32'h900);
    do_pred(32'h950, 1, 0, 1, 0, 0, 1, 32'h123, 1, 32'h456, a);
    chk("R2 return taken", npc_tkn, 1);
    chk("R2 R3 return target is call pc+4", npc, 32'h204);
    flush();
  endtask

  task automatic t_indirect();
    logic a;
    do_pred(32'h300, 1, 0, 0, 0, 0, 1, 32'h111, 1, 32'hA00, a);
    chk("R5 indirect hit target, btb ignored", {npc_tkn, npc}, {1'b1, 32'hA00});
    do_pred(32'h310, 1, 0, 0, 0, 0, 1, 32'h111, 0, 32'hA00, a);
    chk("R5 indirect miss falls through", {npc_tkn, npc}, {1'b0, 32'h314});
    flush();
  endtask

  task automatic t_cond_call();
    logic a;
    do_pred(32'h400, 1, 1, 0, 1, 0, 1, 32'hC00, 0, 0, a);
    do_pred(32'h480, 0, 1, 0, 1, 1, 0, 32'h0, 0, 0, a);
    chk("R6 cond call miss not taken", {npc_tkn, npc}, {1'b0, 32'h484});
    do_pred(32'hC40, 1, 0, 1, 0, 0, 0, 0, 0, 0, a);
    chk("R6 cond call miss left stack unchanged", npc, 32'h404);
    do_pred(32'h500, 1, 1, 0, 1, 0, 0, 32'h0, 0, 0, a);
    chk("R6 uncond call miss not taken", npc_tkn, 0);
    do_pred(32'hC80, 1, 0, 1, 0, 0, 0, 0, 0, 0, a);
    chk("R6 uncond call miss keeps push", npc, 32'h504);
    flush();
  endtask

  task automatic t_commit_misp();
    logic a;
    logic [SEQ_W-1:0] s1, s2, s3;
    s1 = seq_n; do_pred(32'h600, 0, 0, 0, 1, 1, 1, 32'hD00, 0, 0, a);
    s2 = seq_n; do_pred(32'h610, 0, 0, 0, 1, 0, 1, 32'hD10, 0, 0, a);
    s3 = seq_n; do_pred(32'h620, 1, 0, 0, 0, 0, 0, 0, 1, 32'hE20, a);
    do_misp(s2, 1, 32'h777);
    chk("R9 direct entry updates target buffer", {btb_upd_vld, ind_upd_vld}, 2'b10);
    chk("R9 target buffer update pc/tgt", {btb_upd_pc, btb_upd_tgt}, {32'h610, 32'h777});
    do_misp(s3, 1, 32'h888);
    chk("R9 indirect entry updates indirect table", {btb_upd_vld, ind_upd_vld}, 2'b01);
    chk("R9 indirect update seq/tgt", {ind_upd_seq, ind_upd_tgt}, {s3, 32'h888});
    do_misp(s1, 0, 32'h0);
    chk("R9 not-taken correction sends no update", {btb_upd_vld, ind_upd_vld}, 2'b00);
    do_commit(s2);
    chk("R7 commit retires two entries", got_n, 2);
    chk("R7 R9 oldest first with corrected direction", {got_pc[0], got_tk[0]}, {32'h600, 1'b0});
    chk("R7 R9 second retired corrected to taken", {got_pc[1], got_tk[1]}, {32'h610, 1'b1});
    do_commit(s3);
    chk("R7 remaining entry retired", got_n, 1);
    chk("R7 remaining entry payload", {got_pc[0], got_tk[0]}, {32'h620, 1'b1});
  endtask

  task automatic t_squash();
    logic a;
    logic [SEQ_W-1:0] sa;
    sa = seq_n; do_pred(32'h700, 1, 1, 0, 1, 0, 1, 32'hF00, 0, 0, a);
    do_pred(32'h710, 1, 1, 0, 1, 0, 1, 32'hF40, 0, 0, a);
    do_pred(32'h7F0, 1, 0, 1, 0, 0, 0, 0, 0, 0, a);
    chk("R2 return pops younger call", npc, 32'h714);
    do_squash(sa);
    do_pred(32'h7F4, 1, 0, 1, 0, 0, 0, 0, 0, 0, a);
    chk("R8 stack repaired after squash", npc, 32'h704);
    flush();
    chk("R8 only survivors retire", got_n, 2);
    chk("R8 survivor order", {got_pc[0], got_pc[1]}, {32'h700, 32'h7F4});
  endtask

  task automatic t_full();
    logic a;
    for (int k = 0; k < 16; k++) do_pred(32'h2000 + 32'(k * 4), 0, 0, 0, 1, 0, 0, 0, 0, 0, a);
    chk("R10 hq_full after 16 entries", hq_full, 1);
    chk("R10 pred_rdy low when full", pred_rdy, 0);
    do_pred(32'h3000, 1, 0, 0, 1, 0, 1, 32'h3300, 0, 0, a);
    chk("R10 prediction refused when full", {a, npc_vld}, 2'b00);
    flush();
    chk("R10 all 16 entries retire", got_n, 16);
    chk("R10 last retired is youngest accepted", got_pc[15], 32'h203C);
  endtask

  task automatic t_same_cycle();
    logic a;
    logic [SEQ_W-1:0] sa, sc;
    sa = seq_n; do_pred(32'hB00, 0, 0, 0, 1, 0, 0, 0, 0, 0, a);
    do_pred(32'hB10, 0, 0, 0, 1, 0, 0, 0, 0, 0, a);
    sc = seq_n; do_pred(32'hB20, 0, 0, 0, 1, 0, 0, 0, 0, 0, a);
    @(negedge clk);
    sq_req = 1; sq_seq = sa; cmt_req = 1; cmt_seq = sc;
    pred_valid = 1; pred_pc = 32'hB80; pred_seq = seq_n; br_uncond = 1; br_direct = 1; btb_hit = 1;
    #1 chk("R11 pred_rdy low on combined request", pred_rdy, 0);
    @(negedge clk);
    sq_req = 0; cmt_req = 0; pred_valid = 0;
    chk("R11 prediction not accepted", npc_vld, 0);
    collect();
    chk("R11 squash before commit: one retirement", got_n, 1);
    chk("R11 retired entry is the oldest", got_pc[0], 32'hB00);
  endtask

  task automatic t_wrap();
    logic a;
    for (int k = 0; k < 17; k++) begin
      do_pred(32'h4000 + 32'(k * 16), 1, 1, 0, 1, 0, 1, 32'h8000, 0, 0, a);
      flush();
    end
    for (int k = 0; k < 17; k++) begin
      do_pred(32'h9000 + 32'(k * 4), 1, 0, 1, 0, 0, 0, 0, 0, 0, a);
      if (k < 16)
        chk("R10 stack returns in reverse order", npc, 32'h4000 + 32'((16 - k) * 16) + 32'h4);
      else
        chk("R10 pointer wrapped: 17th pop sees 17th push", npc, 32'h4104);
      flush();
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_call_ret();
    t_indirect();
    t_cond_call();
    t_commit_misp();
    t_squash();
    t_full();
    t_same_cycle();
    t_wrap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule